// File: doc/BRIEF.md
# Programmable SYSREF Pulse Generator

The block produces the SYSREF timing reference for a subclass 1 converter link, in the link clock domain. A 32-bit control word picks between a software-driven single pulse, a free-running square wave and a free-running pulse train with a programmable high time. The control word can also hand the output over to an external SYSREF input, which is then passed through. The repetition period is always a whole number of extended multiblocks: `EXT_MB` multiblocks per extended multiblock, `MB_CYC` link clocks per multiblock, times a software multiplier.

Settings that cannot be used are not rejected. They are replaced by safe values. An out-of-range multiplier falls back to 1, and an unusable high time falls back to half the period. The block reads the control word into shadow registers on the first clock after reset and again at each period boundary, so a change made while it runs never cuts a period short. A status word reports the period and high time actually in use.

Top module: `sysref_gen`

## Requirements
- R1: While `rst_ni` is low, `sysref_o` is 0 and `status_o` reports a period of EXT_MB*MB_CYC and a high time of half that.
- R2: The mode is taken from `ctrl_i[1:0]`: 00 gives the single-pulse mode, 01 the square wave, 10 the programmable pulse train, and 11 behaves as 01.
- R3: The multiplier is taken from `ctrl_i[6:2]`. The period is EXT_MB*multiplier*MB_CYC link clocks, and the counter restarts at zero at each period start.
- R4: If EXT_MB*multiplier is 0 or greater than MAX_EM, a multiplier of 1 is used. With EXT_MB=2, a multiplier of 9 gives a 64-clock period.
- R5: In the square-wave mode the output is high for the first period/2 clocks of each period and low for the rest. It rises on the first clock of a period.
- R6: In the pulse-train mode the output is high for the first D clocks of each period, where D is `ctrl_i[16:8]` and 1 <= D <= period-1.
- R7: In the pulse-train mode a D of 0, or a D above period-1, gives a high time of period/2.
- R8: In the single-pulse mode, `sysref_o` equals `ctrl_i[17]` as it was one clock earlier.
- R9: When `ctrl_i[7]` is 0, `sysref_o` equals `ext_sysref_i` as it was one clock earlier, whatever the mode, multiplier and duty fields hold. When `ctrl_i[7]` is 1, the internal generator drives the output.
- R10: `status_o[8:0]` holds the period in use modulo 512 (0 stands for 512), `status_o[17:9]` holds the high time in use, and `status_o[31:18]` is 0.
- R11: The control word is sampled on the first clock after reset and then only on the last clock of each period. A change made in between takes effect at the next period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link clock |
| rst_ni | input | 1 | Asynchronous active-low reset of this block only |
| ctrl_i | input | 32 | Control word: mode, multiplier, source select, duty, manual pulse bit |
| ext_sysref_i | input | 1 | External SYSREF, passed through when selected |
| sysref_o | output | 1 | Registered SYSREF output |
| status_o | output | 32 | Period and high time in use |

## Verification
The bench builds the block with EXT_MB=2 and keeps MB_CYC=32 and MAX_EM=16. With these values, multiplier 8 is the largest legal setting and gives a 512-clock period, which wraps to 0 in the status field. Multiplier 9 becomes illegal and exercises the fallback to a 64-clock period. A 128-clock pulse train lets the legal duty edge of 127 and the first illegal value of 128 be tested side by side. Changes made in the middle of a period, mode 11, manual single pulses, pseudo-random external pass-through and a reset during operation complete the patterns.

// File: rtl/sysref_gen_pkg.sv
package sysref_gen_pkg;
  localparam int CTRL_W     = 32;
  localparam int MODE_LSB   = 0;
  localparam int MULT_LSB   = 2;
  localparam int MULT_W     = 5;
  localparam int SEL_BIT    = 7;
  localparam int DUTY_LSB   = 8;
  localparam int DUTY_W     = 9;
  localparam int MAN_BIT    = 17;
  localparam int STAT_W     = 32;
  localparam int STAT_FLD_W = 9;

  typedef enum logic [1:0] {
    MODE_ONE = 2'b00,
    MODE_PER = 2'b01,
    MODE_GAP = 2'b10
  } sr_mode_e;

  // 11 is not a mode of its own; run it as the square wave
  function automatic sr_mode_e decode_mode(input logic [1:0] fld);
    case (fld)
      2'b00:   return MODE_ONE;
      2'b10:   return MODE_GAP;
      default: return MODE_PER;
    endcase
  endfunction
endpackage

// File: rtl/sysref_gen_cfg.sv
module sysref_gen_cfg
  import sysref_gen_pkg::*;
#(
  parameter int EXT_MB = 1,
  parameter int MB_CYC = 32,
  parameter int MAX_EM = 16,
  parameter int PER_W  = 10
) (
  input  logic [1:0]        mode_fld_i,
  input  logic [MULT_W-1:0] mult_fld_i,
  input  logic [DUTY_W-1:0] duty_fld_i,
  output sr_mode_e          mode_o,
  output logic [PER_W-1:0]  period_o,
  output logic [PER_W-1:0]  duty_o
);
  int prod;
  int mult_eff;
  int per_int;
  int duty_req;

  always_comb begin
    mode_o   = decode_mode(mode_fld_i);
    prod     = EXT_MB * int'(mult_fld_i);
    mult_eff = (prod >= 1 && prod <= MAX_EM) ? int'(mult_fld_i) : 1;
    per_int  = EXT_MB * mult_eff * MB_CYC;
    period_o = PER_W'(per_int);
    duty_req = int'(duty_fld_i);
    if (mode_o == MODE_GAP && duty_req != 0 && duty_req < per_int)
      duty_o = PER_W'(duty_req);
    else
      duty_o = PER_W'(per_int / 2);
  end
endmodule

// File: rtl/sysref_gen_cnt.sv
module sysref_gen_cnt
  import sysref_gen_pkg::*;
#(
  parameter int EXT_MB = 1,
  parameter int MB_CYC = 32,
  parameter int PER_W  = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  sr_mode_e         mode_i,
  input  logic             sel_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [PER_W-1:0] duty_i,
  output sr_mode_e         mode_d_o,
  output logic             sel_d_o,
  output logic             wave_d_o,
  output logic [PER_W-1:0] cnt_o,
  output logic [PER_W-1:0] per_o,
  output logic [PER_W-1:0] duty_o,
  output sr_mode_e         mode_o,
  output logic             sel_o,
  output logic             run_o
);
  localparam logic [PER_W-1:0] RST_PER  = PER_W'(EXT_MB * MB_CYC);
  localparam logic [PER_W-1:0] RST_DUTY = PER_W'(EXT_MB * MB_CYC / 2);

  logic [PER_W-1:0] cnt_q, cnt_d, per_q, per_d, duty_q, duty_d;
  sr_mode_e         mode_q, mode_d;
  logic             sel_q, sel_d, run_q, load;

  // shadow reload on first clock out of reset and on the last clock of a period
  always_comb begin
    load   = !run_q || (cnt_q == per_q - 1'b1);
    cnt_d  = cnt_q + 1'b1;
    per_d  = per_q;
    duty_d = duty_q;
    mode_d = mode_q;
    sel_d  = sel_q;
    if (load) begin
      cnt_d  = '0;
      per_d  = period_i;
      duty_d = duty_i;
      mode_d = mode_i;
      sel_d  = sel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      per_q  <= RST_PER;
      duty_q <= RST_DUTY;
      mode_q <= MODE_ONE;
      sel_q  <= 1'b1;
      run_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      duty_q <= duty_d;
      mode_q <= mode_d;
      sel_q  <= sel_d;
      run_q  <= 1'b1;
    end
  end

  assign mode_d_o = mode_d;
  assign sel_d_o  = sel_d;
  assign wave_d_o = cnt_d < duty_d;
  assign cnt_o    = cnt_q;
  assign per_o    = per_q;
  assign duty_o   = duty_q;
  assign mode_o   = mode_q;
  assign sel_o    = sel_q;
  assign run_o    = run_q;
endmodule

// File: rtl/sysref_gen_out.sv
module sysref_gen_out
  import sysref_gen_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sel_i,
  input  sr_mode_e mode_i,
  input  logic     wave_i,
  input  logic     manual_i,
  input  logic     ext_i,
  output logic     sysref_o
);
  logic nxt, sysref_q;

  always_comb begin
    if (!sel_i)                 nxt = ext_i;
    else if (mode_i == MODE_ONE) nxt = manual_i;
    else                        nxt = wave_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sysref_q <= 1'b0;
    else         sysref_q <= nxt;
  end

  assign sysref_o = sysref_q;
endmodule

// File: rtl/sysref_gen.sv
module sysref_gen
  import sysref_gen_pkg::*;
#(
  parameter int EXT_MB = 1,
  parameter int MB_CYC = 32,
  parameter int MAX_EM = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              ext_sysref_i,
  output logic              sysref_o,
  output logic [STAT_W-1:0] status_o
);
  localparam int MAX_PER = MAX_EM * MB_CYC;
  localparam int PER_W   = $clog2(MAX_PER + 1);
  localparam int FW      = STAT_FLD_W;

  sr_mode_e         cfg_mode, mode_d, mode_q;
  logic [PER_W-1:0] cfg_per, cfg_duty, cnt_q, per_q, duty_q;
  logic             sel_d, wave_d, sel_q, run_q;
  logic             unused_rsvd;

  assign unused_rsvd = ^ctrl_i[CTRL_W-1:MAN_BIT+1];

  sysref_gen_cfg #(
    .EXT_MB(EXT_MB), .MB_CYC(MB_CYC), .MAX_EM(MAX_EM), .PER_W(PER_W)
  ) u_cfg (
    .mode_fld_i (ctrl_i[MODE_LSB +: 2]),
    .mult_fld_i (ctrl_i[MULT_LSB +: MULT_W]),
    .duty_fld_i (ctrl_i[DUTY_LSB +: DUTY_W]),
    .mode_o     (cfg_mode),
    .period_o   (cfg_per),
    .duty_o     (cfg_duty)
  );

  sysref_gen_cnt #(
    .EXT_MB(EXT_MB), .MB_CYC(MB_CYC), .PER_W(PER_W)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_i   (cfg_mode),
    .sel_i    (ctrl_i[SEL_BIT]),
    .period_i (cfg_per),
    .duty_i   (cfg_duty),
    .mode_d_o (mode_d),
    .sel_d_o  (sel_d),
    .wave_d_o (wave_d),
    .cnt_o    (cnt_q),
    .per_o    (per_q),
    .duty_o   (duty_q),
    .mode_o   (mode_q),
    .sel_o    (sel_q),
    .run_o    (run_q)
  );

  sysref_gen_out u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_d),
    .mode_i   (mode_d),
    .wave_i   (wave_d),
    .manual_i (ctrl_i[MAN_BIT]),
    .ext_i    (ext_sysref_i),
    .sysref_o (sysref_o)
  );

  // period field wraps: 512 reads as 0
  assign status_o = {{(STAT_W-2*FW){1'b0}}, FW'(duty_q), FW'(per_q)};
endmodule

// File: rtl/sysref_gen_chk.sv
module sysref_gen_chk
  import sysref_gen_pkg::*;
#(
  parameter int EXT_MB = 1,
  parameter int MB_CYC = 32,
  parameter int MAX_EM = 16,
  parameter int PER_W  = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             manual_i,
  input logic             ext_sysref_i,
  input logic             sysref_o,
  input logic [PER_W-1:0] cnt_q,
  input logic [PER_W-1:0] per_q,
  input logic [PER_W-1:0] duty_q,
  input sr_mode_e         mode_q,
  input logic             sel_q,
  input logic             run_q
);
  localparam int UNIT    = EXT_MB * MB_CYC;
  localparam int MAX_PER = MAX_EM * MB_CYC;

  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < per_q));

  p_period_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (int'(per_q) >= UNIT && int'(per_q) <= MAX_PER && int'(per_q) % UNIT == 0));

  p_half_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && sel_q && mode_q == MODE_PER |-> duty_q == (per_q >> 1));

  p_wave_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && sel_q && mode_q != MODE_ONE |-> sysref_o == (cnt_q < duty_q));

  p_duty_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (duty_q != '0 && duty_q < per_q));

  p_manual_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && sel_q && mode_q == MODE_ONE |-> sysref_o == $past(manual_i));

  p_ext_pass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !sel_q |-> sysref_o == $past(ext_sysref_i));

  p_shadow_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && cnt_q != '0 |-> $stable(per_q) && $stable(duty_q) && $stable(mode_q) && $stable(sel_q));
endmodule

bind sysref_gen sysref_gen_chk #(
  .EXT_MB(EXT_MB), .MB_CYC(MB_CYC), .MAX_EM(MAX_EM), .PER_W(PER_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .manual_i     (ctrl_i[17]),
  .ext_sysref_i (ext_sysref_i),
  .sysref_o     (sysref_o),
  .cnt_q        (cnt_q),
  .per_q        (per_q),
  .duty_q       (duty_q),
  .mode_q       (mode_q),
  .sel_q        (sel_q),
  .run_q        (run_q)
);

// File: tb/sysref_gen_test.sv
`timescale 1ns/1ps
module sysref_gen_test;
  localparam int E = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ctrl_i = '0;
  logic        ext_sysref_i = 1'b0;
  logic        sysref_o;
  logic [31:0] status_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;
  string cur_req = "R1";

  always #4 clk_i = ~clk_i;

  sysref_gen #(.EXT_MB(E)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ctrl_i),
    .ext_sysref_i(ext_sysref_i), .sysref_o(sysref_o), .status_o(status_o)
  );

  // behavioural reference model
  int m_cnt = 0, m_per = E*32, m_duty = E*16, m_mode = 0;
  bit m_sel = 1'b1, m_run = 1'b0, m_out = 1'b0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_per = E*32; m_duty = E*16; m_mode = 0;
      m_sel = 1'b1; m_run = 1'b0; m_out = 1'b0;
    end else begin
      if (!m_run || m_cnt == m_per - 1) begin
        int mult, df;
        mult = int'(ctrl_i[6:2]);
        if (E*mult < 1 || E*mult > 16) mult = 1;
        m_per  = E * mult * 32;
        m_mode = (ctrl_i[1:0] == 2'b11) ? 1 : int'(ctrl_i[1:0]);
        m_sel  = ctrl_i[7];
        df     = int'(ctrl_i[16:8]);
        m_duty = (m_mode == 2 && df >= 1 && df <= m_per - 1) ? df : m_per / 2;
        m_cnt  = 0;
        m_run  = 1'b1;
      end else begin
        m_cnt++;
      end
      if (!m_sel)           m_out = ext_sysref_i;
      else if (m_mode == 0) m_out = ctrl_i[17];
      else                  m_out = (m_cnt < m_duty);
    end
  end

  function automatic logic [31:0] exp_status();
    return {14'b0, 9'(m_duty), 9'(m_per % 512)};
  endfunction

  always @(negedge clk_i) begin
    if (cmp_on) begin
      checks++;
      if (sysref_o !== m_out) begin
        fails++;
        $display("FAIL %s sysref_o actual=%0b expected=%0b at %0t", cur_req, sysref_o, m_out, $time);
      end
      checks++;
      if (status_o !== exp_status()) begin
        fails++;
        $display("FAIL %s status_o actual=%h expected=%h at %0t", cur_req, status_o, exp_status(), $time);
      end
    end
  end

  function automatic logic [31:0] mk(int mode, int mult, bit sel, int duty, bit man);
    logic [31:0] w;
    w = '0;
    w[1:0]  = 2'(mode);
    w[6:2]  = 5'(mult);
    w[7]    = sel;
    w[16:8] = 9'(duty);
    w[17]   = man;
    return w;
  endfunction

  task automatic step(int n);
    repeat (n) @(posedge clk_i);
    #2;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] st(int per, int duty);
    return {14'b0, 9'(duty), 9'(per % 512)};
  endfunction

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    // R1: reset state
    ctrl_i = mk(1, 1, 1'b1, 0, 1'b0);
    cmp_on = 1'b1;
    step(4);
    chk("R1 reset sysref_o", {31'b0, sysref_o}, 32'd0);
    chk("R1 reset status", status_o, st(64, 32));
    rst_ni = 1'b1;

    cur_req = "R3 R5 periodic mult1";
    step(200);
    chk("R3 period 64", status_o, st(64, 32));

    cur_req = "R11 R6 R2 gapped change mid-period";
    step(13);
    ctrl_i = mk(2, 2, 1'b1, 10, 1'b0);
    step(300);
    chk("R6 gapped duty 10", status_o, st(128, 10));

    cur_req = "R7 duty zero";
    ctrl_i = mk(2, 2, 1'b1, 0, 1'b0);
    step(300);
    chk("R7 duty 0 -> half", status_o, st(128, 64));

    cur_req = "R6 duty at period-1";
    ctrl_i = mk(2, 2, 1'b1, 127, 1'b0);
    step(300);
    chk("R6 duty 127 legal", status_o, st(128, 127));

    cur_req = "R7 duty equal period";
    ctrl_i = mk(2, 2, 1'b1, 128, 1'b0);
    step(300);
    chk("R7 duty 128 -> half", status_o, st(128, 64));

    cur_req = "R4 mult 9 illegal";
    ctrl_i = mk(2, 9, 1'b1, 40, 1'b0);
    step(300);
    chk("R4 mult 9 -> 64", status_o, st(64, 40));

    cur_req = "R4 mult 0 illegal";
    ctrl_i = mk(2, 0, 1'b1, 40, 1'b0);
    step(150);
    chk("R4 mult 0 -> 64", status_o, st(64, 40));

    cur_req = "R10 R5 mult 8 period 512";
    ctrl_i = mk(1, 8, 1'b1, 7, 1'b0);
    step(1100);
    chk("R10 period 512 reads 0", status_o, st(512, 256));

    cur_req = "R2 mode 11 as periodic";
    ctrl_i = mk(3, 3, 1'b1, 5, 1'b0);
    step(600);
    chk("R2 mode 11 periodic", status_o, st(192, 96));

    cur_req = "R8 one-shot manual";
    ctrl_i = mk(0, 1, 1'b1, 0, 1'b0);
    step(200);
    for (int k = 0; k < 4; k++) begin
      ctrl_i[17] = 1'b1;
      step(3 + k);
      chk("R8 manual high", {31'b0, sysref_o}, 32'd1);
      ctrl_i[17] = 1'b0;
      step(20);
      chk("R8 manual low", {31'b0, sysref_o}, 32'd0);
    end

    cur_req = "R9 external pass-through";
    ctrl_i = mk(2, 4, 1'b0, 7, 1'b1);
    step(300);
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ext_sysref_i = lfsr[0];
      step(1);
    end
    chk("R9 status while external", status_o, st(256, 7));

    cur_req = "R1 reset mid-run";
    rst_ni = 1'b0;
    step(3);
    chk("R1 mid-run reset sysref_o", {31'b0, sysref_o}, 32'd0);
    chk("R1 mid-run reset status", status_o, st(64, 32));
    ctrl_i = mk(1, 1, 1'b1, 0, 1'b0);
    rst_ni = 1'b1;
    cur_req = "R11 R5 restart after reset";
    step(150);

    cmp_on = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired during %s", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule